// File: doc/BRIEF.md
# Graphics Coprocessor Performance Counter Bank

This block holds three read-only activity counters for a graphics command processor. Software reads them over a simple register bus. A cycle counter advances on every core clock from reset. A command-busy counter advances on each cycle in which the command queue holds work. A pipeline-busy counter advances on each cycle in which the rendering pipeline reports activity. Together they let firmware measure elapsed time and compare it with useful work done over the same interval.

The counters are never loaded. The only way to change them is a clear command: a write to the status offset with the clear bit set returns all three counters to zero together. The processor freeze control does not affect counting. Freeze, queue-not-empty and pipe-busy can be read back as live status bits. Reads are registered. Each read returns the counter values as they stood in the cycle the request was sampled.

Top module: `gpc_perf_bank`

## Requirements
- R1: The cycle counter, read at offset 0x10, is zero after reset and increases by one on every core clock edge after reset is released.
- R2: The freeze input has no effect on any counter value.
- R3: The command-busy counter, read at offset 0x14, increases by one on each clock edge at which fifo_nempty_i is high and holds its value otherwise.
- R4: The pipe-busy counter, read at offset 0x18, increases by one on each clock edge at which pipe_busy_i is high and holds its value otherwise.
- R5: A write to offset 0x0C with data bit 9 set clears all three counters to zero at that edge, even when an increment would occur at the same edge. A write to 0x0C with bit 9 clear changes nothing.
- R6: Writes to offsets 0x10, 0x14 and 0x18 are ignored.
- R7: A read request sampled at a clock edge drives bus_rvalid_o high for the following cycle. In that cycle bus_rdata_o carries the addressed value as of the sampling edge: counter bits in 23:0 and zero in 31:24. bus_rvalid_o is low in cycles that follow no request.
- R8: Each counter wraps from its all-ones value to zero and raises no flag.
- R9: A read of offset 0x0C returns freeze_i in bit 0, fifo_nempty_i in bit 1 and pipe_busy_i in bit 2, with zero elsewhere. A read of any unmapped offset returns zero.
- R10: While rst_ni is low, bus_rdata_o and bus_rvalid_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_nempty_i | input | 1 | Command queue holds at least one entry |
| pipe_busy_i | input | 1 | Rendering pipeline active |
| freeze_i | input | 1 | Processor freeze state (status only) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W (8) | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the request |

## Verification
Wrap-around is the hardest case to reach from the ports. A 24-bit counter needs millions of cycles to wrap. The bench therefore drives a second instance, built with an 8-bit counter width, from the same stimulus. It holds the busy inputs high for several hundred cycles, so that instance wraps several times while the full-width one is checked for ordinary counting. A clear colliding with an active increment is set up by holding both busy inputs high across the clear write. A read issued on the very next edge then shows whether the clear won.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned N_CNT    = 3;
  localparam int unsigned CLR_BIT  = 9;
  localparam logic [7:0]  OFS_STAT = 8'h0C;
  localparam logic [7:0]  OFS_CYC  = 8'h10;
  localparam logic [7:0]  OFS_CMD  = 8'h14;
  localparam logic [7:0]  OFS_PIPE = 8'h18;

  typedef enum logic [1:0] {
    CNT_CYC  = 2'd0,
    CNT_CMD  = 2'd1,
    CNT_PIPE = 2'd2
  } cnt_idx_e;
endpackage

// File: rtl/gpc_counter.sv
module gpc_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] cnt_q;

  // clear dominates increment; wrap is silent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + STEP;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/gpc_read_mux.sv
module gpc_read_mux
  import gpc_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [N_CNT-1:0][CNT_W-1:0]  cnt_i,
  input  logic [2:0]                   stat_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         rvalid_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] sel_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    sel_d = '0;
    if (addr_i == ADDR_W'(OFS_STAT))      sel_d = {{(DATA_W-3){1'b0}}, stat_i};
    else if (addr_i == ADDR_W'(OFS_CYC))  sel_d = {{PAD_W{1'b0}}, cnt_i[CNT_CYC]};
    else if (addr_i == ADDR_W'(OFS_CMD))  sel_d = {{PAD_W{1'b0}}, cnt_i[CNT_CMD]};
    else if (addr_i == ADDR_W'(OFS_PIPE)) sel_d = {{PAD_W{1'b0}}, cnt_i[CNT_PIPE]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= sel_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/gpc_perf_bank.sv
module gpc_perf_bank
  import gpc_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_nempty_i,
  input  logic              pipe_busy_i,
  input  logic              freeze_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o
);
  logic [N_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [N_CNT-1:0]            inc;
  logic                        clr;
  logic                        unused_wdata;

  assign clr = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_STAT)) && bus_wdata_i[CLR_BIT];
  assign unused_wdata = ^bus_wdata_i;

  assign inc[CNT_CYC]  = 1'b1;   // freeze deliberately not involved
  assign inc[CNT_CMD]  = fifo_nempty_i;
  assign inc[CNT_PIPE] = pipe_busy_i;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    gpc_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .inc_i  (inc[g]),
      .cnt_o  (cnt_q[g])
    );
  end

  gpc_read_mux #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (bus_rd_i),
    .addr_i   (bus_addr_i),
    .cnt_i    (cnt_q),
    .stat_i   ({pipe_busy_i, fifo_nempty_i, freeze_i}),
    .rdata_o  (bus_rdata_o),
    .rvalid_o (bus_rvalid_o)
  );
endmodule

// File: rtl/gpc_perf_bank_chk.sv
module gpc_perf_bank_chk
  import gpc_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        fifo_nempty_i,
  input logic                        pipe_busy_i,
  input logic                        bus_wr_i,
  input logic                        bus_rd_i,
  input logic [ADDR_W-1:0]           bus_addr_i,
  input logic [31:0]                 bus_wdata_i,
  input logic [31:0]                 bus_rdata_o,
  input logic                        bus_rvalid_o,
  input logic [N_CNT-1:0][CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic clr_seen;
  logic [CNT_W-1:0] cyc, cmd, pip;
  assign clr_seen = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_STAT)) && bus_wdata_i[CLR_BIT];
  assign cyc = cnt_q[CNT_CYC];
  assign cmd = cnt_q[CNT_CMD];
  assign pip = cnt_q[CNT_PIPE];

  assert_cyc_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_seen |=> cyc == $past(cyc) + ONE);

  assert_cmd_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_seen && fifo_nempty_i) |=> cmd == $past(cmd) + ONE);

  assert_cmd_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_seen && !fifo_nempty_i) |=> $stable(cmd));

  assert_pipe_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_seen && pipe_busy_i) |=> pip == $past(pip) + ONE);

  assert_pipe_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_seen && !pipe_busy_i) |=> $stable(pip));

  assert_clear_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_seen |=> (cyc == '0) && (cmd == '0) && (pip == '0));

  assert_rvalid_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i |=> bus_rvalid_o);

  assert_rvalid_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> !bus_rvalid_o);

  assert_upper_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o |-> bus_rdata_o[31:24] == 8'h00);
endmodule

bind gpc_perf_bank gpc_perf_bank_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fifo_nempty_i (fifo_nempty_i),
  .pipe_busy_i   (pipe_busy_i),
  .bus_wr_i      (bus_wr_i),
  .bus_rd_i      (bus_rd_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .bus_rvalid_o  (bus_rvalid_o),
  .cnt_q         (cnt_q)
);

// File: tb/gpc_perf_bank_tb.sv
module gpc_perf_bank_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_ne = 1'b0, pipe_b = 1'b0, frz = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_w, rdata_n;
  logic        rvalid_w, rvalid_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string cur_tag = "";

  // bench model of the counters (24-bit)
  logic [23:0] m_cyc = '0, m_cmd = '0, m_pip = '0;
  logic [31:0] exp_w_q[$];
  logic [31:0] exp_n_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpc_perf_bank #(.CNT_W(24), .ADDR_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_nempty_i(fifo_ne), .pipe_busy_i(pipe_b),
    .freeze_i(frz), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_w), .bus_rvalid_o(rvalid_w)
  );

  gpc_perf_bank #(.CNT_W(8), .ADDR_W(8)) u_dut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .fifo_nempty_i(fifo_ne), .pipe_busy_i(pipe_b),
    .freeze_i(frz), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_n), .bus_rvalid_o(rvalid_n)
  );

  function automatic logic [31:0] expect_val(logic [7:0] a, int w);
    logic [31:0] mask;
    mask = (w == 24) ? 32'h00FF_FFFF : 32'h0000_00FF;
    case (a)
      8'h0C:   return {29'd0, pipe_b, fifo_ne, frz};
      8'h10:   return {8'd0, m_cyc} & mask;
      8'h14:   return {8'd0, m_cmd} & mask;
      8'h18:   return {8'd0, m_pip} & mask;
      default: return 32'd0;
    endcase
  endfunction

  // model + scoreboard push: expected is pre-edge value
  always @(posedge clk) begin
    if (rst_n) begin
      if (rd) begin
        exp_w_q.push_back(expect_val(addr, 24));
        exp_n_q.push_back(expect_val(addr, 8));
        tag_q.push_back(cur_tag);
      end
      if (wr && addr == 8'h0C && wdata[9]) begin
        m_cyc = '0; m_cmd = '0; m_pip = '0;
      end else begin
        m_cyc = m_cyc + 24'd1;
        if (fifo_ne) m_cmd = m_cmd + 24'd1;
        if (pipe_b)  m_pip = m_pip + 24'd1;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && (rvalid_w || rvalid_n)) begin
      logic [31:0] ew, en;
      string t;
      if (exp_w_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: rvalid without request, actual=%0b expected=0", rvalid_w);
      end else begin
        ew = exp_w_q.pop_front();
        en = exp_n_q.pop_front();
        t  = tag_q.pop_front();
        checks++;
        if (!rvalid_w || rdata_w !== ew) begin
          errors++;
          $display("FAIL %s: wide rdata actual=%h expected=%h (rvalid=%0b)", t, rdata_w, ew, rvalid_w);
        end
        checks++;
        if (!rvalid_n || rdata_n !== en) begin
          errors++;
          $display("FAIL %s: narrow rdata actual=%h expected=%h (rvalid=%0b)", t, rdata_n, en, rvalid_n);
        end
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input string t);
    @(negedge clk);
    cur_tag = t; rd = 1'b1; addr = a; wr = 1'b0;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; rd = 1'b0;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : wdog
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (rdata_w !== 32'd0 || rdata_n !== 32'd0) begin
      errors++; $display("FAIL R10: rdata actual=%h/%h expected=0", rdata_w, rdata_n);
    end
    checks++;
    if (rvalid_w !== 1'b0 || rvalid_n !== 1'b0) begin
      errors++; $display("FAIL R10: rvalid actual=%0b/%0b expected=0", rvalid_w, rvalid_n);
    end
    rst_n = 1'b1;

    idle(4);
    do_read(8'h10, "R1");
    do_read(8'h14, "R3");
    do_read(8'h18, "R4");

    // busy activity with toggling pipe pattern
    fifo_ne = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); pipe_b = i[0];
    end
    do_read(8'h14, "R3");
    do_read(8'h18, "R4");
    fifo_ne = 1'b0; pipe_b = 1'b1;
    idle(7);
    do_read(8'h14, "R3");
    do_read(8'h18, "R4");
    pipe_b = 1'b0;

    // R2 freeze has no effect
    frz = 1'b1; fifo_ne = 1'b1;
    idle(5);
    do_read(8'h10, "R2");
    do_read(8'h14, "R2");
    do_read(8'h0C, "R9");
    frz = 1'b0; fifo_ne = 1'b0;

    // R6 writes to counter offsets ignored
    do_write(8'h10, 32'hFFFF_FFFF);
    do_write(8'h14, 32'hFFFF_FFFF);
    do_write(8'h18, 32'h0000_0000);
    do_read(8'h10, "R6");
    do_read(8'h14, "R6");
    do_read(8'h18, "R6");

    // R5 status write without clear bit
    do_write(8'h0C, 32'hFFFF_FDFF);
    do_read(8'h10, "R5");

    // R5 clear colliding with increments, read on the next edge
    fifo_ne = 1'b1; pipe_b = 1'b1;
    idle(3);
    @(negedge clk);
    wr = 1'b1; addr = 8'h0C; wdata = 32'h0000_0200;
    @(negedge clk);
    wr = 1'b0; wdata = '0; rd = 1'b1; addr = 8'h14; cur_tag = "R5";
    @(negedge clk);
    addr = 8'h18; cur_tag = "R5";
    @(negedge clk);
    addr = 8'h10; cur_tag = "R5";
    @(negedge clk);
    rd = 1'b0;

    // R9 status bits and unmapped offsets
    fifo_ne = 1'b0; pipe_b = 1'b1; frz = 1'b0;
    do_read(8'h0C, "R9");
    fifo_ne = 1'b1; pipe_b = 1'b0; frz = 1'b1;
    do_read(8'h0C, "R9");
    frz = 1'b0;
    do_read(8'h00, "R9");
    do_read(8'h1C, "R9");

    // R8 wrap (narrow instance wraps several times)
    fifo_ne = 1'b1; pipe_b = 1'b1;
    idle(600);
    do_read(8'h14, "R8");
    do_read(8'h18, "R8");
    do_read(8'h10, "R8");
    fifo_ne = 1'b0; pipe_b = 1'b0;

    idle(4);
    checks++;
    if (exp_w_q.size() != 0) begin
      errors++; $display("FAIL R7: pending reads actual=%0d expected=0", exp_w_q.size());
    end
    done = 1'b1;
    summary();
  end
endmodule